// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the address for a synchronous burst memory. A starting address is captured whenever either of two active-low load strobes is seen low at a rising clock edge. One strobe comes from the processor side and one from the cache-controller side; they act the same way. After a load, each cycle in which the active-low advance input is low moves the burst to its next beat. The two least-significant address bits walk through four beats and then wrap. The upper address bits stay at the loaded value for the whole burst.

An active-low order-select input picks the beat order when a load happens. Low selects linear order, in which the low bits count up modulo four from the loaded value. High selects interleaved order, in which the low bits are the loaded bits XOR the beat number. High is the default when the input is left undriven. The chosen order stays fixed until the next load. The burst feature is optional: a fresh address may be loaded on every cycle, and each one appears on the next cycle.

All inputs are sampled on the rising clock edge. The address output and the valid flag are registered.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high and after it is released, until the first load, `addr_out` is 0 and `addr_valid` is 0.
- R2: A clock edge with `proc_strobe_n` low loads `addr_in`. From the next cycle, `addr_out` equals that value and `addr_valid` is 1.
- R3: A clock edge with `ctrl_strobe_n` low loads exactly as in R2. With both strobes low, the load also behaves as in R2.
- R4: Linear order (`linear_n`=0 at the load): after k accepted advances, `addr_out[1:0]` = (loaded[1:0] + k) mod 4. The upper bits equal the loaded upper bits.
- R5: Interleaved order (`linear_n`=1 at the load): after k accepted advances, `addr_out[1:0]` = loaded[1:0] XOR (k mod 4). The upper bits equal the loaded upper bits.
- R6: A burst wraps. After four advances, `addr_out` again equals the loaded address.
- R7: When a strobe and `adv_n` are both low at the same edge, the strobe wins. `addr_in` is loaded at beat 0 and no advance takes place.
- R8: With both strobes and `adv_n` high, `addr_out` and `addr_valid` keep their values.
- R9: An advance before any load since reset is ignored. `addr_out` stays 0 and `addr_valid` stays 0.
- R10: The order is captured only at a load. Changing `linear_n` in the middle of a burst does not change the sequence.
- R11: Loads on consecutive cycles each take effect one cycle later, with no lost or delayed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_strobe_n | input | 1 | Processor-side load strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Burst advance enable, active low |
| linear_n | input | 1 | Order select at load: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Current burst address (registered) |
| addr_valid | output | 1 | A burst address has been loaded |

## Verification
Every result is due exactly one cycle after the edge that samples its stimulus. This covers a load, an advance, a hold and an ignored advance: each changes only the `addr_out` and `addr_valid` registers. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each check sees the register state written by the single rising edge in between. The sweep covers every low-bit starting value in both orders and through every strobe combination. It also runs bursts longer than four beats, so the wrap is checked in both orders.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2
  } burst_cmd_e;

  typedef enum logic {
    ORD_INTERLEAVED = 1'b0,
    ORD_LINEAR      = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_load_sel.sv
module burst_load_sel
  import burst_pkg::*;
(
  input  logic       proc_strobe_n,
  input  logic       ctrl_strobe_n,
  input  logic       adv_n,
  input  logic       burst_live,
  output burst_cmd_e cmd
);

  // Either strobe loads and outranks the advance; an advance needs a live burst.
  always_comb begin
    if (!proc_strobe_n || !ctrl_strobe_n) begin
      cmd = CMD_LOAD;
    end else if (!adv_n && burst_live) begin
      cmd = CMD_STEP;
    end else begin
      cmd = CMD_HOLD;
    end
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  burst_cmd_e        cmd,
  input  logic              linear_n,
  output logic [BEAT_W-1:0] beat_d,
  output burst_order_e      order_d,
  output logic              live_q
);

  logic [BEAT_W-1:0] beat_q;
  burst_order_e      order_q;

  always_comb begin
    beat_d  = beat_q;
    order_d = order_q;
    unique case (cmd)
      CMD_LOAD: begin
        beat_d  = '0;
        order_d = linear_n ? ORD_INTERLEAVED : ORD_LINEAR;
      end
      CMD_STEP: beat_d = beat_q + 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q  <= '0;
      order_q <= ORD_INTERLEAVED;
      live_q  <= 1'b0;
    end else begin
      beat_q  <= beat_d;
      order_q <= order_d;
      if (cmd == CMD_LOAD) live_q <= 1'b1;
    end
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_STEP) |=> (beat_q == $past(beat_q) + 1'b1)); // R6
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LOAD) |=> (beat_q == '0 && live_q)); // R2
  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_LOAD) |=> $stable(order_q)); // R10

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [ADDR_W-1:0] addr
);

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;
  logic [BEAT_W-1:0] sel_lo;

  assign lin_lo = base[BEAT_W-1:0] + beat;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
    assign ilv_lo[i] = base[i] ^ beat[i];
  end

  assign sel_lo = (order == ORD_LINEAR) ? lin_lo : ilv_lo;

  if (ADDR_W > BEAT_W) begin : g_upper
    assign addr = {base[ADDR_W-1:BEAT_W], sel_lo};
  end else begin : g_low_only
    assign addr = sel_lo;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              linear_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);

  burst_cmd_e        cmd;
  logic [BEAT_W-1:0] beat_d;
  burst_order_e      order_d;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic [ADDR_W-1:0] addr_d;

  burst_load_sel u_sel (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .burst_live    (addr_valid),
    .cmd           (cmd)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .linear_n (linear_n),
    .beat_d   (beat_d),
    .order_d  (order_d),
    .live_q   (addr_valid)
  );

  assign base_d = (cmd == CMD_LOAD) ? addr_in : base_q;

  burst_order_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_map (
    .base  (base_d),
    .beat  (beat_d),
    .order (order_d),
    .addr  (addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      addr_out <= '0;
    end else begin
      base_q   <= base_d;
      addr_out <= addr_d;
    end
  end

  AST_LOAD_SEEN: assert property (@(posedge clk) disable iff (rst)
    (!proc_strobe_n || !ctrl_strobe_n) |=> (addr_out == $past(addr_in) && addr_valid)); // R7
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    (proc_strobe_n && ctrl_strobe_n && adv_n) |=> ($stable(addr_out) && $stable(addr_valid))); // R8
  AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!addr_valid && proc_strobe_n && ctrl_strobe_n) |=> (!addr_valid && $stable(addr_out))); // R9
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (proc_strobe_n && ctrl_strobe_n) |=> ($stable(addr_out[ADDR_W-1:BEAT_W]))); // R4

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          proc_strobe_n, ctrl_strobe_n, adv_n, linear_n;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic          addr_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state, built from the requirements
  int m_base = 0;
  int m_k    = 0;
  bit m_lin  = 1'b0;
  bit m_val  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) dut (
    .clk           (clk),
    .rst           (rst),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .linear_n      (linear_n),
    .addr_in       (addr_in),
    .addr_out      (addr_out),
    .addr_valid    (addr_valid)
  );

  function automatic int exp_addr();
    int lo;
    if (!m_val) return 0;
    if (m_lin) lo = ((m_base % 4) + m_k) % 4;
    else       lo = (m_base % 4) ^ (m_k % 4);
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic check(input string req);
    int e;
    e = exp_addr();
    checks++;
    if (addr_out !== AW'(e) || addr_valid !== m_val) begin
      errors++;
      $display("FAIL %s: addr=%0d valid=%0b expected addr=%0d valid=%0b",
               req, addr_out, addr_valid, e, m_val);
    end
  endtask

  // drive at a falling edge, update the reference for the next rising edge,
  // sample at the following falling edge
  task automatic cyc(input bit p, input bit c, input bit a, input bit l,
                     input int ad, input string req);
    proc_strobe_n = p; ctrl_strobe_n = c; adv_n = a; linear_n = l;
    addr_in = AW'(ad);
    if (!p || !c) begin
      m_base = ad % (1 << AW); m_k = 0; m_lin = !l; m_val = 1'b1;
    end else if (!a && m_val) begin
      m_k = (m_k + 1) % 4;
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    rst = 1'b1; proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1;
    adv_n = 1'b1; linear_n = 1'b1; addr_in = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset");

    // advance before any load is ignored
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 1, 8'hA5, "R9 advance with no burst");
    cyc(1, 1, 1, 0, 8'h3C, "R8 idle hold");

    // sweep: both orders, all start offsets, all strobe combinations
    for (int mode = 0; mode < 2; mode++) begin
      for (int s = 0; s < 12; s++) begin
        int ad;
        bit p, c;
        ad = (s * 53 + mode * 29) % 256;
        p  = (s % 3 == 1);
        c  = (s % 3 == 0);
        cyc(p, c, 1, mode[0], ad, (s % 3 == 0) ? "R2 processor load" :
                                  (s % 3 == 1) ? "R3 controller load" : "R3 both strobes");
        for (int k = 1; k <= 6; k++) begin
          cyc(1, 1, 0, (k == 2) ? !mode[0] : mode[0], 0,
              mode ? "R5 interleaved step" : "R4 linear step");
          if (k == 3) cyc(1, 1, 1, !mode[0], 0, "R10 order flip while holding");
          if (k == 4) begin
            checks++;
            if (addr_out !== AW'(ad)) begin
              errors++;
              $display("FAIL R6: wrap addr=%0d expected %0d", addr_out, ad);
            end
          end
        end
      end
    end

    // strobe beats advance
    cyc(1, 0, 1, 0, 8'h12, "R3 load");
    cyc(1, 1, 0, 0, 0, "R4 step");
    cyc(0, 1, 0, 0, 8'h77, "R7 strobe with advance");
    cyc(1, 1, 0, 1, 0, "R7 burst restarted at beat 0");
    cyc(1, 0, 0, 1, 8'h9A, "R7 controller strobe with advance");

    // back-to-back loads
    for (int i = 0; i < 16; i++)
      cyc(i % 2, (i + 1) % 2, i % 3 == 0, i % 2, i * 17 + 3, "R11 load every cycle");

    // reset mid-burst, then advances ignored again
    rst = 1'b1; m_val = 1'b0; m_base = 0; m_k = 0;
    @(negedge clk);
    check("R1 reset mid-burst");
    rst = 1'b0;
    cyc(1, 1, 0, 0, 8'hFF, "R9 advance after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule